// File: doc/BRIEF.md
# SIMD Pixel Pack and Expand Unit

This unit carries out five pixel-formatting operations on 64-bit SIMD operands. It can narrow signed 16-bit lanes to unsigned bytes. It can narrow signed 32-bit lanes to unsigned bytes, keeping a shifted copy of the previous destination. It can narrow signed 32-bit lanes to saturated signed halfwords. It can widen unsigned bytes into 16-bit fixed-point lanes. It can also interleave the bytes of two 32-bit sources. Each narrowing lane is shifted left by a scale taken from a control byte, shifted arithmetically right by a fixed amount that depends on the variant, and then clamped to the target range.

An issuing pipeline presents an opcode, two source operands, the old destination value and the control byte, together with a one-cycle `in_valid` strobe. The result is registered and appears one clock later, with `out_valid` high for that one cycle. An opcode the unit does not recognise yields a zero result with `out_illegal` set.

The output handshake is a two-state machine. `ST_IDLE` means no result is being presented. `ST_PRESENT` means the registered result is fresh. The transition IDLE->PRESENT (or PRESENT->PRESENT) is taken on any clock with `in_valid` high. The transition PRESENT->IDLE (or IDLE->IDLE) is taken on any clock with `in_valid` low. Synchronous reset forces `ST_IDLE`.

Top module: `pxfmt_unit`

## Requirements
- R1: Opcodes are 9'h03b (halfword pack), 9'h03a (word pack), 9'h03d (fixed pack), 9'h04d (expand) and 9'h04b (merge). Any other opcode registers a zero result with `out_illegal` high alongside `out_valid`. `out_illegal` is low for every recognised opcode.
- R2: A result and `out_valid` appear on the clock edge after the one on which `in_valid` is high. `out_valid` stays low in every cycle not directly preceded by a strobe. `result` and `out_illegal` hold their values while no strobe arrives.
- R3: Synchronous reset (`rst` high at a clock edge) clears `result`, `out_valid` and `out_illegal` to zero, including when a strobe is present in the same cycle.
- R4: Halfword pack (9'h03b) uses the scale `fmt_ctl[6:3]`. Each signed lane `src_b[16i+15:16i]` is shifted left by the scale, arithmetically right by 7, and clamped to 0..255. The result byte goes to `result[8i+7:8i]`. `result[63:32]` is zero, and `fmt_ctl[7]` has no effect.
- R5: Word pack (9'h03a) uses the scale `fmt_ctl[7:3]`. For word w (0 or 1), `result[32w+31:32w+8]` equals `dst_old[32w+23:32w]`. `result[32w+7:32w]` is the signed lane `src_b[32w+31:32w]` shifted left by the scale, arithmetically right by 23, and clamped to 0..255.
- R6: Fixed pack (9'h03d) uses the scale `fmt_ctl[7:3]`. Each signed lane `src_b[32w+31:32w]` is shifted left by the scale, arithmetically right by 16, and clamped to -32768..32767. The halfword is placed at `result[16w+15:16w]`, and `result[63:32]` is zero.
- R7: Expand (9'h04d) takes byte i of `src_b[31:0]` and places it, shifted left by 4, in `result[16i+15:16i]`. The top and bottom four bits of each lane are zero.
- R8: Merge (9'h04b) places byte i of `src_b[31:0]` at result byte 2i and byte i of `src_a[31:0]` at result byte 2i+1.
- R9: Scaled intermediates never wrap. At the largest scale (31 for word lanes, 15 for halfword lanes), a positive lane of 1 saturates to the maximum and a lane of -1 reaches the minimum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation strobe |
| op | input | 9 | Operation code |
| src_a | input | 64 | First source operand |
| src_b | input | 64 | Second source operand |
| dst_old | input | 64 | Current destination value, used by word pack |
| fmt_ctl | input | 8 | Control byte carrying the scale in bits [7:3] |
| result | output | 64 | Registered result |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_illegal | output | 1 | Unrecognised opcode flag, valid with `out_valid` |

## Verification
The hardest condition to reach from the ports is the one where a scaled lane leaves the width of its own source lane. At that point a narrow intermediate would wrap and clamp the wrong way, whereas the correct datapath saturates. The stimulus reaches this condition by programming the largest scale in `fmt_ctl` and supplying single-bit positive and all-ones negative lanes. This drives each clamp into both its upper and lower bounds. Word pack also depends on `dst_old`, so distinct patterns in every byte of that input expose misplaced or unmasked bytes.

// File: rtl/pxfmt_pkg.sv
`timescale 1ns/1ps
package pxfmt_pkg;
    localparam int WORD_W = 64;
    localparam int BYTE_W = 8;
    localparam int HALF_W = 16;
    localparam int SGL_W  = 32;
    localparam int OPC_W  = 9;
    localparam int CTL_W  = 8;
    localparam int SC_H_W = 4;   // scale width for halfword lanes
    localparam int SC_W_W = 5;   // scale width for word lanes
    localparam int SC_LSB = 3;   // scale field starts here in the control byte

    typedef enum logic [OPC_W-1:0] {
        OPC_PACK_H   = 9'h03b,
        OPC_PACK_W   = 9'h03a,
        OPC_PACK_FIX = 9'h03d,
        OPC_EXPAND   = 9'h04d,
        OPC_MERGE    = 9'h04b
    } opc_e;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_PRESENT = 1'b1
    } ostate_e;
endpackage

// File: rtl/pxfmt_sat_lane.sv
`timescale 1ns/1ps
module pxfmt_sat_lane #(
    parameter int IN_W       = 16,
    parameter int SC_W       = 4,
    parameter int SH         = 7,
    parameter int OUT_W      = 8,
    parameter bit SIGNED_OUT = 1'b0
) (
    input  logic [IN_W-1:0]  lane_in,
    input  logic [SC_W-1:0]  scale,
    output logic [OUT_W-1:0] lane_out
);
    // Wide enough that a left shift by the largest scale keeps every bit.
    localparam int WIDE_W = IN_W + (1 << SC_W);
    localparam logic signed [WIDE_W-1:0] ONE = 1;

    logic signed [WIDE_W-1:0] ext;
    logic signed [WIDE_W-1:0] scaled;
    logic signed [WIDE_W-1:0] shifted;

    assign ext     = {{(WIDE_W-IN_W){lane_in[IN_W-1]}}, lane_in};
    assign scaled  = ext <<< scale;
    assign shifted = scaled >>> SH;

    generate
        if (SIGNED_OUT) begin : g_signed
            localparam logic signed [WIDE_W-1:0] MAXV = (ONE <<< (OUT_W-1)) - ONE;
            localparam logic signed [WIDE_W-1:0] MINV = -(ONE <<< (OUT_W-1));
            assign lane_out = (shifted > MAXV) ? MAXV[OUT_W-1:0] :
                              (shifted < MINV) ? MINV[OUT_W-1:0] :
                                                 shifted[OUT_W-1:0];
        end else begin : g_unsigned
            localparam logic signed [WIDE_W-1:0] MAXV = (ONE <<< OUT_W) - ONE;
            assign lane_out = (shifted > MAXV)    ? MAXV[OUT_W-1:0] :
                              (shifted < 'sd0)    ? '0 :
                                                    shifted[OUT_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/pxfmt_pack.sv
`timescale 1ns/1ps
module pxfmt_pack
    import pxfmt_pkg::*;
(
    input  logic [WORD_W-1:0] src_b,
    input  logic [WORD_W-1:0] dst_old,
    input  logic [SC_H_W-1:0] scale_h,
    input  logic [SC_W_W-1:0] scale_w,
    output logic [WORD_W-1:0] pk_half,
    output logic [WORD_W-1:0] pk_word,
    output logic [WORD_W-1:0] pk_fix
);
    localparam int NH = WORD_W / HALF_W;
    localparam int NW = WORD_W / SGL_W;

    genvar i;
    generate
        for (i = 0; i < NH; i++) begin : g_half
            logic [BYTE_W-1:0] b;
            pxfmt_sat_lane #(.IN_W(HALF_W), .SC_W(SC_H_W), .SH(7),
                             .OUT_W(BYTE_W), .SIGNED_OUT(1'b0)) u_lane (
                .lane_in (src_b[HALF_W*i +: HALF_W]),
                .scale   (scale_h),
                .lane_out(b)
            );
            assign pk_half[BYTE_W*i +: BYTE_W] = b;
        end
        assign pk_half[WORD_W-1:NH*BYTE_W] = '0;

        for (i = 0; i < NW; i++) begin : g_word
            logic [BYTE_W-1:0]  b;
            logic [HALF_W-1:0]  h;
            pxfmt_sat_lane #(.IN_W(SGL_W), .SC_W(SC_W_W), .SH(23),
                             .OUT_W(BYTE_W), .SIGNED_OUT(1'b0)) u_lane_w (
                .lane_in (src_b[SGL_W*i +: SGL_W]),
                .scale   (scale_w),
                .lane_out(b)
            );
            pxfmt_sat_lane #(.IN_W(SGL_W), .SC_W(SC_W_W), .SH(16),
                             .OUT_W(HALF_W), .SIGNED_OUT(1'b1)) u_lane_f (
                .lane_in (src_b[SGL_W*i +: SGL_W]),
                .scale   (scale_w),
                .lane_out(h)
            );
            // old destination moves up one byte inside each word; the
            // byte that would cross in from below is replaced by the lane
            assign pk_word[SGL_W*i +: SGL_W] = {dst_old[SGL_W*i +: SGL_W-BYTE_W], b};
            assign pk_fix[HALF_W*i +: HALF_W] = h;
        end
        assign pk_fix[WORD_W-1:NW*HALF_W] = '0;
    endgenerate

    logic unused_dst;
    assign unused_dst = ^{dst_old[31:24], dst_old[63:56]};
endmodule

// File: rtl/pxfmt_spread.sv
`timescale 1ns/1ps
module pxfmt_spread
    import pxfmt_pkg::*;
(
    input  logic [SGL_W-1:0]  lo_a,
    input  logic [SGL_W-1:0]  lo_b,
    output logic [WORD_W-1:0] expanded,
    output logic [WORD_W-1:0] merged
);
    localparam int NB  = SGL_W / BYTE_W;
    localparam int PAD = (HALF_W - BYTE_W) / 2;

    genvar i;
    generate
        for (i = 0; i < NB; i++) begin : g_byte
            assign expanded[HALF_W*i +: HALF_W] =
                {{PAD{1'b0}}, lo_b[BYTE_W*i +: BYTE_W], {PAD{1'b0}}};
            assign merged[HALF_W*i +: HALF_W] =
                {lo_a[BYTE_W*i +: BYTE_W], lo_b[BYTE_W*i +: BYTE_W]};
        end
    endgenerate
endmodule

// File: rtl/pxfmt_unit.sv
`timescale 1ns/1ps
module pxfmt_unit
    import pxfmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [OPC_W-1:0]  op,
    input  logic [WORD_W-1:0] src_a,
    input  logic [WORD_W-1:0] src_b,
    input  logic [WORD_W-1:0] dst_old,
    input  logic [CTL_W-1:0]  fmt_ctl,
    output logic [WORD_W-1:0] result,
    output logic              out_valid,
    output logic              out_illegal
);
    ostate_e           state_q;
    logic [WORD_W-1:0] res_q;
    logic              ill_q;
    logic [WORD_W-1:0] nxt_res;
    logic              nxt_ill;

    logic [WORD_W-1:0] pk_half, pk_word, pk_fix, expanded, merged;

    pxfmt_pack u_pack (
        .src_b  (src_b),
        .dst_old(dst_old),
        .scale_h(fmt_ctl[SC_LSB +: SC_H_W]),
        .scale_w(fmt_ctl[SC_LSB +: SC_W_W]),
        .pk_half(pk_half),
        .pk_word(pk_word),
        .pk_fix (pk_fix)
    );

    pxfmt_spread u_spread (
        .lo_a    (src_a[SGL_W-1:0]),
        .lo_b    (src_b[SGL_W-1:0]),
        .expanded(expanded),
        .merged  (merged)
    );

    always_comb begin
        nxt_res = '0;
        nxt_ill = 1'b0;
        unique case (op)
            OPC_PACK_H:   nxt_res = pk_half;
            OPC_PACK_W:   nxt_res = pk_word;
            OPC_PACK_FIX: nxt_res = pk_fix;
            OPC_EXPAND:   nxt_res = expanded;
            OPC_MERGE:    nxt_res = merged;
            default:      nxt_ill = 1'b1;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:    state_q <= in_valid ? ST_PRESENT : ST_IDLE;
                ST_PRESENT: state_q <= in_valid ? ST_PRESENT : ST_IDLE;
                default:    state_q <= ST_IDLE;
            endcase
        end
    end

    // output registers
    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            ill_q <= 1'b0;
        end else if (in_valid) begin
            res_q <= nxt_res;
            ill_q <= nxt_ill;
        end
    end

    assign result      = res_q;
    assign out_illegal = ill_q;
    assign out_valid   = (state_q == ST_PRESENT);

    logic unused_bits;
    assign unused_bits = ^{src_a[WORD_W-1:SGL_W], fmt_ctl[SC_LSB-1:0]};
endmodule

// File: rtl/pxfmt_unit_chk.sv
`timescale 1ns/1ps
module pxfmt_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [8:0]  op,
    input logic [63:0] src_a,
    input logic [63:0] src_b,
    input logic [63:0] dst_old,
    input logic [7:0]  fmt_ctl,
    input logic [63:0] result,
    input logic        out_valid,
    input logic        out_illegal
);
    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_valid_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_result_holds_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(result) && $stable(out_illegal)));

    assert_illegal_zero_R1: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> (result == 64'd0));

    assert_illegal_known_R1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 9'h04b) |=> !out_illegal);

    assert_half_upper_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 9'h03b) |=> (result[63:32] == 32'd0));

    assert_word_keeps_dst_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 9'h03a) |=>
            (result[31:8] == $past(dst_old[23:0]) && result[63:40] == $past(dst_old[55:32])));

    assert_fix_upper_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 9'h03d) |=> (result[63:32] == 32'd0));

    assert_expand_pad_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 9'h04d) |=>
            ((result & 64'hF00F_F00F_F00F_F00F) == 64'd0));

    assert_merge_src_b_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 9'h04b) |=>
            (result[7:0] == $past(src_b[7:0]) && result[15:8] == $past(src_a[7:0])));
endmodule

bind pxfmt_unit pxfmt_unit_chk chk (.*);

// File: tb/pxfmt_unit_test.sv
`timescale 1ns/1ps
module pxfmt_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [8:0]  op;
    logic [63:0] src_a, src_b, dst_old;
    logic [7:0]  fmt_ctl;
    logic [63:0] result;
    logic        out_valid, out_illegal;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pxfmt_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
        .src_a(src_a), .src_b(src_b), .dst_old(dst_old), .fmt_ctl(fmt_ctl),
        .result(result), .out_valid(out_valid), .out_illegal(out_illegal)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // ---------- reference models written from the requirements ----------
    function automatic logic [63:0] ref_pack_h(logic [63:0] b, logic [7:0] c);
        logic [63:0] r = '0;
        for (int i = 0; i < 4; i++) begin
            longint v = longint'($signed(b[16*i +: 16]));
            v = (v <<< c[6:3]) >>> 7;
            if (v > 255) v = 255;
            if (v < 0) v = 0;
            r[8*i +: 8] = v[7:0];
        end
        return r;
    endfunction

    function automatic logic [63:0] ref_pack_w(logic [63:0] b, logic [63:0] d, logic [7:0] c);
        logic [63:0] r = (d << 8) & ~64'h0000_00ff_0000_00ff;
        for (int w = 0; w < 2; w++) begin
            longint v = longint'($signed(b[32*w +: 32]));
            v = (v <<< c[7:3]) >>> 23;
            if (v > 255) v = 255;
            if (v < 0) v = 0;
            r[32*w +: 8] = r[32*w +: 8] | v[7:0];
        end
        return r;
    endfunction

    function automatic logic [63:0] ref_pack_fix(logic [63:0] b, logic [7:0] c);
        logic [63:0] r = '0;
        for (int w = 0; w < 2; w++) begin
            longint v = longint'($signed(b[32*w +: 32]));
            v = (v <<< c[7:3]) >>> 16;
            if (v > 32767) v = 32767;
            if (v < -32768) v = -32768;
            r[16*w +: 16] = v[15:0];
        end
        return r;
    endfunction

    // ---------- stimulus helpers ----------
    task automatic issue(input logic [8:0] o, input logic [63:0] a, input logic [63:0] b,
                         input logic [63:0] d, input logic [7:0] c);
        @(negedge clk);
        op = o; src_a = a; src_b = b; dst_old = d; fmt_ctl = c; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_check(input string req, input logic [8:0] o, input logic [63:0] a,
                             input logic [63:0] b, input logic [63:0] d, input logic [7:0] c,
                             input logic [63:0] exp);
        issue(o, a, b, d, c);
        check({req, " result"}, result, exp);
        check({req, " valid"}, {63'd0, out_valid}, 64'd1);
        check({req, " illegal"}, {63'd0, out_illegal}, 64'd0);
    endtask

    // ---------- scenarios ----------
    task automatic test_reset();
        check("R3 reset result", result, 64'd0);
        check("R3 reset valid", {63'd0, out_valid}, 64'd0);
        issue(9'h04b, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 64'd0, 8'd0);
        @(negedge clk);
        op = 9'h04b; in_valid = 1'b1; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0; in_valid = 1'b0;
        check("R3 reset with strobe result", result, 64'd0);
        check("R3 reset with strobe valid", {63'd0, out_valid}, 64'd0);
        check("R3 reset with strobe illegal", {63'd0, out_illegal}, 64'd0);
    endtask

    task automatic test_pack_h();
        logic [63:0] b = {16'h7fff, 16'h8000, 16'h0100, 16'h0080};
        run_check("R4 pack_h scale0", 9'h03b, 64'd0, b, 64'd0, 8'h00, ref_pack_h(b, 8'h00));
        check("R4 pack_h literal", result, 64'h0000_0000_ff00_0201);
        run_check("R4 pack_h scale3", 9'h03b, 64'd0, 64'h0040_ffc0_0011_0003,
                  64'd0, 8'h18, ref_pack_h(64'h0040_ffc0_0011_0003, 8'h18));
        // bit 7 of the control byte must not reach the halfword scale
        run_check("R4 pack_h ctl bit7 ignored", 9'h03b, 64'd0, b, 64'd0, 8'h80, ref_pack_h(b, 8'h00));
    endtask

    task automatic test_pack_w();
        logic [63:0] d = 64'h8877_6655_4433_2211;
        logic [63:0] b = {32'h0012_3456, 32'hff00_0000};
        run_check("R5 pack_w scale0", 9'h03a, 64'd0, b, d, 8'h00, ref_pack_w(b, d, 8'h00));
        check("R5 pack_w literal", result, 64'h7766_5500_3322_1100);
        run_check("R5 pack_w scale10", 9'h03a, 64'd0, 64'h0000_4000_0000_0123,
                  d, 8'h50, ref_pack_w(64'h0000_4000_0000_0123, d, 8'h50));
    endtask

    task automatic test_pack_fix();
        logic [63:0] b = {32'h7fff_0000, 32'hfffe_8000};
        run_check("R6 pack_fix scale0", 9'h03d, 64'd0, b, 64'd0, 8'h00, ref_pack_fix(b, 8'h00));
        check("R6 pack_fix literal", result, 64'h0000_0000_7fff_fffe);
        run_check("R6 pack_fix scale4", 9'h03d, 64'd0, 64'h0123_4567_f800_0000,
                  64'd0, 8'h20, ref_pack_fix(64'h0123_4567_f800_0000, 8'h20));
    endtask

    task automatic test_expand();
        run_check("R7 expand", 9'h04d, 64'hffff_ffff_ffff_ffff, 64'hdead_beef_ff80_017f,
                  64'd0, 8'hff, 64'h0ff0_0800_0010_07f0);
    endtask

    task automatic test_merge();
        run_check("R8 merge", 9'h04d ^ 9'h006, 64'hAAAA_AAAA_4433_2211,
                  64'hBBBB_BBBB_8877_6655, 64'd0, 8'd0, 64'h4488_3377_2266_1155);
    endtask

    task automatic test_illegal();
        issue(9'h1ff, 64'h1, 64'h2, 64'h3, 8'h08);
        check("R1 illegal result", result, 64'd0);
        check("R1 illegal flag", {63'd0, out_illegal}, 64'd1);
        check("R1 illegal valid", {63'd0, out_valid}, 64'd1);
        issue(9'h03c, 64'h1, 64'h2, 64'h3, 8'h08);
        check("R1 near opcode illegal", {63'd0, out_illegal}, 64'd1);
    endtask

    task automatic test_hold();
        logic [63:0] keep;
        issue(9'h04d, 64'd0, 64'h0000_0000_0102_0304, 64'd0, 8'd0);
        keep = result;
        check("R2 valid after strobe", {63'd0, out_valid}, 64'd1);
        @(negedge clk);
        check("R2 valid drops", {63'd0, out_valid}, 64'd0);
        src_b = 64'hffff_ffff_ffff_ffff; op = 9'h04b;
        @(negedge clk);
        @(negedge clk);
        check("R2 result holds", result, keep);
        check("R2 valid stays low", {63'd0, out_valid}, 64'd0);
    endtask

    task automatic test_wide();
        run_check("R9 fix scale31", 9'h03d, 64'd0, {32'hffff_ffff, 32'h0000_0001},
                  64'd0, 8'hf8, 64'h0000_0000_8000_7fff);
        run_check("R9 word scale31", 9'h03a, 64'd0, {32'hffff_ffff, 32'h0000_0001},
                  64'd0, 8'hf8, 64'h0000_0000_0000_00ff);
        run_check("R9 half scale15", 9'h03b, 64'd0, {16'hffff, 16'h0001, 16'hffff, 16'h0001},
                  64'd0, 8'h78, 64'h0000_0000_00ff_00ff);
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; op = '0;
        src_a = '0; src_b = '0; dst_old = '0; fmt_ctl = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        test_reset();
        test_pack_h();
        test_pack_w();
        test_pack_fix();
        test_expand();
        test_merge();
        test_illegal();
        test_hold();
        test_wide();
        @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule